// File: doc/BRIEF.md
# Sequential Integer Divider with Divide-Error Trap

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock, in either unsigned or two's-complement signed arithmetic. It has two operand sizes. In the narrow size, a `W`-bit dividend (taken from `dividend_lo`) is divided by an `H`-bit divisor (taken from `divisor[H-1:0]`). The results are an `H`-bit quotient and an `H`-bit remainder. In the wide size, a `2W`-bit dividend (`{dividend_hi, dividend_lo}`) is divided by a `W`-bit divisor, and the results are a `W`-bit quotient and remainder. Here `H = HALF_W` and `W = 2*HALF_W`; the defaults are 8 and 16.

A caller pulses `start` with the operands and the two mode selects. It then waits for the one-cycle `done` pulse. When the divisor is zero, or the true quotient does not fit its field, the block raises `trap` together with `done` and leaves the result outputs untouched. The divider works on magnitudes. It then negates the quotient when the operand signs differ, and negates the remainder when the dividend is negative, so division truncates toward zero.

The controller has four states:
- ST_IDLE waits for `start`.
- ST_SHIFT runs one restoring step per cycle.
- ST_SETTLE applies the sign fix-up and the signed range check.
- ST_REPORT raises `done`.

The transitions are:
- ST_IDLE goes to ST_SHIFT on `start`. It goes straight to ST_REPORT when the high half of the dividend magnitude is not below the divisor magnitude, which covers both a zero divisor and a too-large quotient.
- ST_SHIFT goes to ST_SETTLE after its last step.
- ST_SETTLE goes to ST_REPORT.
- ST_REPORT returns to ST_IDLE.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done` and `trap` are low and `quotient` and `remainder` are zero.
- R2: Unsigned narrow size: `quotient[H-1:0]` = `dividend_lo` / `divisor[H-1:0]` and `remainder[H-1:0]` = `dividend_lo` mod `divisor[H-1:0]`. The upper `H` bits of both outputs are zero. `dividend_hi` and `divisor[W-1:H]` have no effect.
- R3: Unsigned wide size: `quotient` and `remainder` are the quotient and remainder of `{dividend_hi, dividend_lo}` divided by `divisor`.
- R4: A zero divisor (in the active size) ends the operation with `done` and `trap` both high.
- R5: In unsigned mode, a quotient above 2^H-1 (narrow) or 2^W-1 (wide) ends with `trap`.
- R6: In signed mode, the quotient is truncated toward zero and the remainder takes the sign of the dividend. Both are written in two's complement into their field, so in the narrow size bits `[H-1:0]` hold the value and the upper bits are zero.
- R7: In signed mode, a quotient above 2^(n-1)-1 or below -(2^(n-1)-1) ends with `trap`. Here n = H (narrow) or W (wide), so the most negative code is also a trap.
- R8: `done` is high for exactly one cycle per operation, and `trap` is high only while `done` is. On a trap, `quotient` and `remainder` keep their previous values.
- R9: `busy` rises in the cycle after `start` is sampled and stays high up to and including the `done` cycle. A non-trapping operation raises `done` exactly n+1 clock edges after the edge that sampled `start`.
- R10: A `start` while `busy` is high does not alter the running operation and does not launch another. `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled when idle |
| is_signed | input | 1 | 1 selects two's-complement operands |
| word_mode | input | 1 | 1 selects the wide size, 0 the narrow size |
| dividend_hi | input | W | Upper dividend half (wide size only) |
| dividend_lo | input | W | Lower dividend half; whole dividend in narrow size |
| divisor | input | W | Divisor; only bits [H-1:0] in narrow size |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Divide error, valid with `done` |
| quotient | output | W | Quotient of the last successful operation |
| remainder | output | W | Remainder of the last successful operation |

## Verification
The hardest case to reach is the signed range trap that only shows after the loop has finished. Examples are a narrow dividend of -128 divided by 1, or a wide dividend of -32768 divided by -1. In these cases the early test passes, because the high half of the magnitude is below the divisor, yet the quotient magnitude lands exactly on 2^(n-1). The bench uses a reduced size (`HALF_W` = 4) so that the narrow size can be swept over every dividend and divisor code in both signednesses. Every boundary quotient of this kind, and every early trap, therefore occurs. The wide size is covered by a lattice of dividends and divisors plus hand-picked most-negative cases. A separate run pulses `start` in the middle of an operation.

// File: rtl/itdiv_pkg.sv
`timescale 1ns/1ps
package itdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_REPORT = 2'd3
    } div_state_t;
endpackage

// File: rtl/div_operand_prep.sv
`timescale 1ns/1ps
// Selects operands for the active size, takes magnitudes, and aligns them
// for the shift-subtract loop. Also performs the early overflow test.
module div_operand_prep #(
    parameter int HALF_W = 8
) (
    input  logic                  is_signed,
    input  logic                  word_mode,
    input  logic [2*HALF_W-1:0]   dvd_hi,
    input  logic [2*HALF_W-1:0]   dvd_lo,
    input  logic [2*HALF_W-1:0]   dvs,
    output logic [2*HALF_W-1:0]   rem_init,
    output logic [2*HALF_W-1:0]   quo_init,
    output logic [2*HALF_W-1:0]   dvs_mag,
    output logic                  neg_quo,
    output logic                  neg_rem,
    output logic                  early_trap
);
    localparam int W  = 2 * HALF_W;
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_full;
    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_full;
    logic          dvd_neg;
    logic          dvs_neg;

    always_comb begin
        if (word_mode) begin
            dvd_full = {dvd_hi, dvd_lo};
            dvd_neg  = is_signed & dvd_hi[W-1];
            dvs_full = dvs;
            dvs_neg  = is_signed & dvs[W-1];
        end else begin
            dvd_full = {{W{is_signed & dvd_lo[W-1]}}, dvd_lo};
            dvd_neg  = is_signed & dvd_lo[W-1];
            dvs_full = {{HALF_W{is_signed & dvs[HALF_W-1]}}, dvs[HALF_W-1:0]};
            dvs_neg  = is_signed & dvs[HALF_W-1];
        end
        dvd_mag = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;
        dvs_mag = dvs_neg ? (~dvs_full + 1'b1) : dvs_full;
        if (word_mode) begin
            rem_init = dvd_mag[DW-1:W];
            quo_init = dvd_mag[W-1:0];
        end else begin
            rem_init = {{HALF_W{1'b0}}, dvd_mag[W-1:HALF_W]};
            quo_init = {dvd_mag[HALF_W-1:0], {HALF_W{1'b0}}};
        end
        neg_quo    = dvd_neg ^ dvs_neg;
        neg_rem    = dvd_neg;
        early_trap = (rem_init >= dvs_mag);
    end
endmodule

// File: rtl/div_step.sv
`timescale 1ns/1ps
// One restoring shift-subtract step: yields one quotient bit.
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        trial   = {rem_in, quo_in[W-1]};
        diff    = trial - {1'b0, dvs};
        fits    = (trial >= {1'b0, dvs});
        rem_out = fits ? diff[W-1:0] : trial[W-1:0];
        quo_out = {quo_in[W-2:0], fits};
    end
endmodule

// File: rtl/div_result_fix.sv
`timescale 1ns/1ps
// Applies result signs, masks the narrow size, and checks the signed range.
module div_result_fix #(
    parameter int HALF_W = 8
) (
    input  logic [2*HALF_W-1:0] qmag,
    input  logic [2*HALF_W-1:0] rmag,
    input  logic                neg_quo,
    input  logic                neg_rem,
    input  logic                is_signed,
    input  logic                word_mode,
    output logic [2*HALF_W-1:0] quo,
    output logic [2*HALF_W-1:0] rem,
    output logic                limit_trap
);
    localparam int W = 2 * HALF_W;

    logic [W-1:0] quo_s;
    logic [W-1:0] rem_s;

    always_comb begin
        quo_s = neg_quo ? (~qmag + 1'b1) : qmag;
        rem_s = neg_rem ? (~rmag + 1'b1) : rmag;
        if (word_mode) begin
            quo        = quo_s;
            rem        = rem_s;
            limit_trap = is_signed & qmag[W-1];
        end else begin
            quo        = {{HALF_W{1'b0}}, quo_s[HALF_W-1:0]};
            rem        = {{HALF_W{1'b0}}, rem_s[HALF_W-1:0]};
            limit_trap = is_signed & qmag[HALF_W-1];
        end
    end
endmodule

// File: rtl/iter_divider.sv
`timescale 1ns/1ps
module iter_divider #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                is_signed,
    input  logic                word_mode,
    input  logic [2*HALF_W-1:0] dividend_hi,
    input  logic [2*HALF_W-1:0] dividend_lo,
    input  logic [2*HALF_W-1:0] divisor,
    output logic                busy,
    output logic                done,
    output logic                trap,
    output logic [2*HALF_W-1:0] quotient,
    output logic [2*HALF_W-1:0] remainder
);
    import itdiv_pkg::*;

    localparam int W  = 2 * HALF_W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_WIDE   = CW'(W - 1);
    localparam logic [CW-1:0] LAST_NARROW = CW'(HALF_W - 1);

    div_state_t   state, state_nx;

    logic [W-1:0]  work_rem, work_quo, work_dvs;
    logic          neg_quo_q, neg_rem_q, signed_q, wide_q, trap_q;
    logic [CW-1:0] step_cnt;
    logic [W-1:0]  quot_q, remo_q;

    logic [W-1:0]  p_rem, p_quo, p_dvs;
    logic          p_negq, p_negr, p_early;
    logic [W-1:0]  s_rem, s_quo;
    logic [W-1:0]  f_quo, f_rem;
    logic          f_limit;
    logic          last_step;

    div_operand_prep #(.HALF_W(HALF_W)) u_prep (
        .is_signed  (is_signed),
        .word_mode  (word_mode),
        .dvd_hi     (dividend_hi),
        .dvd_lo     (dividend_lo),
        .dvs        (divisor),
        .rem_init   (p_rem),
        .quo_init   (p_quo),
        .dvs_mag    (p_dvs),
        .neg_quo    (p_negq),
        .neg_rem    (p_negr),
        .early_trap (p_early)
    );

    div_step #(.W(W)) u_step (
        .rem_in  (work_rem),
        .quo_in  (work_quo),
        .dvs     (work_dvs),
        .rem_out (s_rem),
        .quo_out (s_quo)
    );

    div_result_fix #(.HALF_W(HALF_W)) u_fix (
        .qmag       (work_quo),
        .rmag       (work_rem),
        .neg_quo    (neg_quo_q),
        .neg_rem    (neg_rem_q),
        .is_signed  (signed_q),
        .word_mode  (wide_q),
        .quo        (f_quo),
        .rem        (f_rem),
        .limit_trap (f_limit)
    );

    assign last_step = (step_cnt == (wide_q ? LAST_WIDE : LAST_NARROW));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = p_early ? ST_REPORT : ST_SHIFT;
            ST_SHIFT:  if (last_step) state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_rem  <= '0;
            work_quo  <= '0;
            work_dvs  <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            signed_q  <= 1'b0;
            wide_q    <= 1'b0;
            trap_q    <= 1'b0;
            step_cnt  <= '0;
            quot_q    <= '0;
            remo_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    work_rem  <= p_rem;
                    work_quo  <= p_quo;
                    work_dvs  <= p_dvs;
                    neg_quo_q <= p_negq;
                    neg_rem_q <= p_negr;
                    signed_q  <= is_signed;
                    wide_q    <= word_mode;
                    trap_q    <= p_early;
                    step_cnt  <= '0;
                end
                ST_SHIFT: begin
                    work_rem <= s_rem;
                    work_quo <= s_quo;
                    step_cnt <= step_cnt + 1'b1;
                end
                ST_SETTLE: begin
                    if (f_limit) begin
                        trap_q <= 1'b1;
                    end else begin
                        quot_q <= f_quo;
                        remo_q <= f_rem;
                    end
                end
                ST_REPORT: trap_q <= trap_q;
                default: trap_q <= trap_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_REPORT);
        trap      = (state == ST_REPORT) && trap_q;
        quotient  = quot_q;
        remainder = remo_q;
    end
endmodule

// File: rtl/iter_divider_checker.sv
`timescale 1ns/1ps
module iter_divider_checker #(
    parameter int HALF_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                is_signed,
    input logic                word_mode,
    input logic [2*HALF_W-1:0] dividend_hi,
    input logic [2*HALF_W-1:0] divisor,
    input logic                busy,
    input logic                done,
    input logic                trap,
    input logic [2*HALF_W-1:0] quotient,
    input logic [2*HALF_W-1:0] remainder
);
    logic zero_dvs;
    assign zero_dvs = word_mode ? (divisor == '0) : (divisor[HALF_W-1:0] == '0);

    assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && zero_dvs) |=> (done && trap));

    assert_unsigned_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !is_signed && word_mode && (dividend_hi >= divisor)) |=> (done && trap));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_trap_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done);

    assert_hold_on_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trap) |-> ($stable(quotient) && $stable(remainder)));

    assert_busy_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_done_implies_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind iter_divider iter_divider_checker #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_signed   (is_signed),
    .word_mode   (word_mode),
    .dividend_hi (dividend_hi),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .trap        (trap),
    .quotient    (quotient),
    .remainder   (remainder)
);

// File: tb/iter_divider_bench.sv
`timescale 1ns/1ps
module iter_divider_bench;
    localparam int H = 4;
    localparam int W = 2 * H;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic         word_mode = 1'b0;
    logic [W-1:0] dividend_hi = '0;
    logic [W-1:0] dividend_lo = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, trap;
    logic [W-1:0] quotient, remainder;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;

    always #2.5 clk = ~clk;

    iter_divider #(.HALF_W(H)) u_iter_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .word_mode(word_mode), .dividend_hi(dividend_hi), .dividend_lo(dividend_lo),
        .divisor(divisor), .busy(busy), .done(done), .trap(trap),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input bit sg, input bit wm, input logic [W-1:0] hi,
                          input logic [W-1:0] lo, input logic [W-1:0] dv,
                          input bit hit_busy);
        int n, d, q, r, lim_hi, lim_lo, cyc, steps;
        bit exp_trap;
        logic [W-1:0] eq, er;
        string tag;
        if (!wm) begin
            if (sg) begin n = $signed(lo); d = $signed(dv[H-1:0]); lim_hi = 7; lim_lo = -7; end
            else begin n = lo; d = dv[H-1:0]; lim_hi = 15; lim_lo = 0; end
            steps = H;
        end else begin
            if (sg) begin n = $signed({hi, lo}); d = $signed(dv); lim_hi = 127; lim_lo = -127; end
            else begin n = {hi, lo}; d = dv; lim_hi = 255; lim_lo = 0; end
            steps = W;
        end
        q = 0; r = 0;
        if (d == 0) exp_trap = 1'b1;
        else begin
            q = n / d; r = n % d;
            exp_trap = (q > lim_hi) || (q < lim_lo);
        end
        if (!wm) begin eq = W'(q) & W'(15); er = W'(r) & W'(15); end
        else begin eq = W'(q); er = W'(r); end
        if (d == 0) tag = "R4";
        else if (exp_trap) tag = sg ? "R7" : "R5";
        else tag = sg ? "R6" : (wm ? "R3" : "R2");

        @(negedge clk);
        is_signed = sg; word_mode = wm; dividend_hi = hi; dividend_lo = lo; divisor = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9", "busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 64) begin
            if (hit_busy && cyc == 2) begin
                start = 1'b1; dividend_lo = ~lo; divisor = dv ^ W'(1);
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 64) begin
            chk(1'b0, tag, "watchdog: no done", cyc, steps + 1);
            return;
        end
        chk(trap == exp_trap, tag, "trap", trap, exp_trap);
        if (exp_trap) begin
            chk(quotient == last_q, "R8", "quotient held on trap", quotient, last_q);
            chk(remainder == last_r, "R8", "remainder held on trap", remainder, last_r);
        end else begin
            chk(quotient == eq, tag, "quotient", quotient, eq);
            chk(remainder == er, tag, "remainder", remainder, er);
            chk(cyc == steps + 1, "R9", "latency", cyc, steps + 1);
            last_q = eq; last_r = er;
        end
        @(negedge clk);
        chk(!done && !trap, "R8", "done single pulse", done, 0);
        chk(!busy, "R10", "idle after done", busy, 0);
        if (hit_busy) begin
            for (int k = 0; k < 2 * W; k++) begin
                @(negedge clk);
                chk(!done && !busy, "R10", "no second operation", done, 0);
            end
        end
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !trap, "R1", "idle flags after reset", {busy, done, trap}, 0);
        chk(quotient == '0 && remainder == '0, "R1", "zero results after reset",
            {quotient, remainder}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Narrow size: every dividend and divisor code, both signednesses (R2, R4-R7)
        for (int sg = 0; sg < 2; sg++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 16; b++)
                    run_op(sg[0], 1'b0, W'(a) ^ 8'hA5, W'(a),
                           {W'(a)}[H-1:0] << H | W'(b), 1'b0);

        // Wide size: lattice of operands
        for (int sg = 0; sg < 2; sg++)
            for (int i = 0; i < 32; i++)
                for (int j = 0; j < 24; j++) begin
                    logic [2*W-1:0] v;
                    v = (2*W)'(j * 2731 + i * 7);
                    run_op(sg[0], 1'b1, v[2*W-1:W], v[W-1:0], W'(i * 8 + (i % 8)), 1'b0);
                end

        // Wide-size signed corner cases (R6, R7)
        run_op(1'b1, 1'b1, 8'h80, 8'h00, 8'hFF, 1'b0); // -32768 / -1 -> trap
        run_op(1'b1, 1'b1, 8'hFF, 8'h02, 8'h02, 1'b0); // -254 / 2 = -127
        run_op(1'b1, 1'b1, 8'hFF, 8'h00, 8'h02, 1'b0); // -256 / 2 -> trap
        run_op(1'b1, 1'b1, 8'h00, 8'h7F, 8'h01, 1'b0); // 127 / 1
        run_op(1'b1, 1'b1, 8'h00, 8'h80, 8'h01, 1'b0); // 128 / 1 -> trap
        run_op(1'b0, 1'b1, 8'hFE, 8'hFF, 8'hFF, 1'b0); // largest unsigned quotient
        run_op(1'b0, 1'b1, 8'h12, 8'h34, 8'h00, 1'b0); // zero divisor

        // Start pulsed mid-operation is ignored (R10)
        run_op(1'b0, 1'b1, 8'h01, 8'h23, 8'h45, 1'b1);
        run_op(1'b1, 1'b0, 8'h00, 8'hD3, 8'h05, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule